// File: doc/BRIEF.md
# Per-Flow Virtual Path / Virtual Circuit Route Lookup

This block sits in the cell path of a four-port packet router edge. Each cell arrives as a fixed number of 32-bit words, tagged with the port it came from. The four ports are the line card, the switch fabric, and two processing modules. The first word of a cell carries the virtual path and virtual circuit identifiers. The block uses them to pick a destination port for the whole cell. It then forwards every word, unchanged, together with a 2-bit destination tag that a downstream crossbar acts on.

Two routing tables are read in parallel. The per-flow circuit table is indexed by the circuit identifier and the aggregate path table is indexed by the path identifier. Each table entry holds an independent valid bit and destination for every input port. A valid circuit entry wins over a valid path entry. When neither entry is valid, a fixed default route for the input port applies. A host-side write port changes one port's slot of one entry per cycle. Any slot can name any destination, so ingress processing (line card to module), egress processing (switch to module) and loopback to the originating side are all programmable.

A two-state framer (ST_IDLE waiting for a header, ST_BODY counting payload words) decides which words belong to a cell. There are two transitions. ST_IDLE goes to ST_BODY on a valid word with the start flag set. ST_BODY goes back to ST_IDLE on the last word of the cell.

Top module: `flow_route_lookup`

## Requirements
- R1: A cell starts with a word that has in_valid=1 and in_soc=1 while no cell is open. It then takes CELL_WORDS (default 13) valid words in total. An in_soc flag raised on a word inside an open cell is ignored: that word is forwarded with out_soc=0 and the cell length is unchanged.
- R2: Valid words that arrive while no cell is open, and without in_soc, are dropped. out_valid stays 0 for them.
- R3: Every accepted word appears on out_data exactly two cycles after it is presented. out_valid=1 marks it, and out_soc=1 marks only the header word.
- R4: out_dest takes its new value together with the header word on the output. It holds that value for every later word of the same cell.
- R5: The header word carries the path identifier in bits [31:20] and the circuit identifier in bits [19:4]. The circuit table is indexed by bits [13:4] and the path table by bits [29:20], so identifiers that differ only above those bits share an entry.
- R6: If the circuit-table slot for the cell's input port is valid, out_dest is that slot's destination, whatever the path table holds.
- R7: If the circuit slot is invalid and the path-table slot for the input port is valid, out_dest is the path slot's destination.
- R8: If neither slot is valid, the default applies. Port codes are 0 for the line card, 1 for the switch, 2 for module A and 3 for module B. The default routes are 0→1, 1→0, 2→1 and 3→0.
- R9: Entries are kept per input port: writing one port's slot has no effect on lookups for cells from the other ports.
- R10: A write with wr_en=1 sets the slot wr_port of entry wr_idx to wr_valid and wr_dest. wr_tbl=0 selects the circuit table and wr_tbl=1 the path table. Any destination is accepted, including module ports and the cell's own input port (loopback).
- R11: A write to the same entry and slot in the same cycle as a header's lookup gives that header the old contents. The next header sees the new contents.
- R12: After reset, every slot of both tables is invalid, out_valid=0 and out_dest=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input word present |
| in_soc | input | 1 | Input word is a cell header |
| in_port | input | 2 | Input port of the cell (code per R8) |
| in_data | input | 32 | Input word |
| wr_en | input | 1 | Table write strobe |
| wr_tbl | input | 1 | 0 = circuit table, 1 = path table |
| wr_port | input | 2 | Input-port slot to write |
| wr_idx | input | 10 | Entry index |
| wr_valid | input | 1 | New valid bit |
| wr_dest | input | 2 | New destination |
| out_valid | output | 1 | Output word present |
| out_soc | output | 1 | Output word is a header |
| out_data | output | 32 | Forwarded word |
| out_dest | output | 2 | Destination tag for the current cell |

## Verification
The bench aims at the lookup priority. It shows a circuit entry overriding a path entry and then, after it is invalidated, the path entry taking over again; a design with the priority reversed, or one that ignored the valid bits, would route those cells to the wrong port. A write landing in the same cycle as a header is checked to return the old route. A table with write-first forwarding would hand the new route to that header. Identifiers whose upper bits differ but whose index bits match must reach the same entry; indexing from the wrong bit field breaks that. A start flag inside a cell, and a stray word after the cell, must neither restart framing nor leak to the output, which a framer that trusts every start flag would get wrong.

// File: rtl/flow_route_pkg.sv
package flow_route_pkg;

    localparam int NPORTS  = 4;
    localparam int PORT_W  = 2;
    localparam int VPI_LSB = 20;
    localparam int VCI_LSB = 4;

    typedef logic [PORT_W-1:0] port_t;

    localparam port_t PORT_LINE   = 2'd0;
    localparam port_t PORT_SWITCH = 2'd1;
    localparam port_t PORT_MOD_A  = 2'd2;
    localparam port_t PORT_MOD_B  = 2'd3;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_BODY = 1'b1
    } frm_state_e;

    // Fixed fall-back route when no table slot is valid.
    function automatic port_t default_route(input port_t src);
        port_t d;
        unique case (src)
            PORT_LINE:   d = PORT_SWITCH;
            PORT_SWITCH: d = PORT_LINE;
            PORT_MOD_A:  d = PORT_SWITCH;
            default:     d = PORT_LINE;
        endcase
        return d;
    endfunction

endpackage

// File: rtl/flow_tbl.sv
module flow_tbl
    import flow_route_pkg::*;
#(
    parameter int IDX_W = 10
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [IDX_W-1:0]         rd_idx,
    output logic [NPORTS-1:0]        rd_valid,
    output logic [NPORTS*PORT_W-1:0] rd_dest,
    input  logic                     wr_en,
    input  logic [IDX_W-1:0]         wr_idx,
    input  port_t                    wr_port,
    input  logic                     wr_valid,
    input  port_t                    wr_dest
);
    localparam int DEPTH = 1 << IDX_W;

    // Valid bits live in resettable flops; destinations in plain storage.
    logic [DEPTH-1:0]         vld_q [NPORTS];
    logic [NPORTS*PORT_W-1:0] dst_mem [DEPTH];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int p = 0; p < NPORTS; p++) begin
                vld_q[p] <= '0;
            end
            rd_valid <= '0;
        end else begin
            for (int p = 0; p < NPORTS; p++) begin
                rd_valid[p] <= vld_q[p][rd_idx];
            end
            if (wr_en) begin
                vld_q[wr_port][wr_idx] <= wr_valid;
            end
        end
    end

    // Read-before-write: a colliding read sees the old word.
    always_ff @(posedge clk) begin
        rd_dest <= dst_mem[rd_idx];
        if (wr_en) begin
            dst_mem[wr_idx][int'(wr_port)*PORT_W +: PORT_W] <= wr_dest;
        end
    end

endmodule

// File: rtl/route_resolve.sv
module route_resolve
    import flow_route_pkg::*;
(
    input  port_t                    src,
    input  logic [NPORTS-1:0]        vc_valid,
    input  logic [NPORTS*PORT_W-1:0] vc_dest,
    input  logic [NPORTS-1:0]        vp_valid,
    input  logic [NPORTS*PORT_W-1:0] vp_dest,
    output port_t                    dest
);
    logic  vc_hit;
    logic  vp_hit;
    port_t vc_sel;
    port_t vp_sel;

    always_comb begin
        vc_hit = vc_valid[src];
        vp_hit = vp_valid[src];
        vc_sel = vc_dest[int'(src)*PORT_W +: PORT_W];
        vp_sel = vp_dest[int'(src)*PORT_W +: PORT_W];
        if (vc_hit) begin
            dest = vc_sel;
        end else if (vp_hit) begin
            dest = vp_sel;
        end else begin
            dest = default_route(src);
        end
    end

endmodule

// File: rtl/cell_framer.sv
module cell_framer
    import flow_route_pkg::*;
#(
    parameter int CELL_WORDS = 13
) (
    input  logic clk,
    input  logic rst_n,
    input  logic in_valid,
    input  logic in_soc,
    output logic accept,
    output logic header
);
    localparam int CNT_W = $clog2(CELL_WORDS);
    localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(CELL_WORDS - 1);

    frm_state_e       state_q;
    frm_state_e       state_d;
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            if (header) begin
                cnt_q <= CNT_W'(1);
            end else if (accept) begin
                cnt_q <= cnt_q + CNT_W'(1);
            end
        end
    end

    always_comb begin
        state_d = state_q;
        accept  = 1'b0;
        header  = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (in_valid && in_soc) begin
                    accept  = 1'b1;
                    header  = 1'b1;
                    state_d = ST_BODY;
                end
            end
            ST_BODY: begin
                if (in_valid) begin
                    accept = 1'b1;
                    if (cnt_q == LAST_CNT) begin
                        state_d = ST_IDLE;
                    end
                end
            end
        endcase
    end

endmodule

// File: rtl/flow_route_lookup.sv
module flow_route_lookup
    import flow_route_pkg::*;
#(
    parameter int IDX_W      = 10,
    parameter int DATA_W     = 32,
    parameter int CELL_WORDS = 13
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic              in_soc,
    input  logic [1:0]        in_port,
    input  logic [DATA_W-1:0] in_data,
    input  logic              wr_en,
    input  logic              wr_tbl,
    input  logic [1:0]        wr_port,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic              wr_valid,
    input  logic [1:0]        wr_dest,
    output logic              out_valid,
    output logic              out_soc,
    output logic [DATA_W-1:0] out_data,
    output logic [1:0]        out_dest
);
    localparam int NTBL = 2;   // 0: circuit table, 1: path table

    logic accept;
    logic header;

    logic [NPORTS-1:0]        tbl_valid [NTBL];
    logic [NPORTS*PORT_W-1:0] tbl_dest  [NTBL];
    logic [IDX_W-1:0]         tbl_idx   [NTBL];

    logic              s1_valid;
    logic              s1_hdr;
    logic [DATA_W-1:0] s1_data;
    port_t             s1_port;
    port_t             route;

    assign tbl_idx[0] = in_data[VCI_LSB +: IDX_W];
    assign tbl_idx[1] = in_data[VPI_LSB +: IDX_W];

    cell_framer #(.CELL_WORDS(CELL_WORDS)) u_framer (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (in_valid),
        .in_soc   (in_soc),
        .accept   (accept),
        .header   (header)
    );

    for (genvar t = 0; t < NTBL; t++) begin : g_tbl
        flow_tbl #(.IDX_W(IDX_W)) u_tbl (
            .clk      (clk),
            .rst_n    (rst_n),
            .rd_idx   (tbl_idx[t]),
            .rd_valid (tbl_valid[t]),
            .rd_dest  (tbl_dest[t]),
            .wr_en    (wr_en && (wr_tbl == 1'(t))),
            .wr_idx   (wr_idx),
            .wr_port  (wr_port),
            .wr_valid (wr_valid),
            .wr_dest  (wr_dest)
        );
    end

    route_resolve u_resolve (
        .src      (s1_port),
        .vc_valid (tbl_valid[0]),
        .vc_dest  (tbl_dest[0]),
        .vp_valid (tbl_valid[1]),
        .vp_dest  (tbl_dest[1]),
        .dest     (route)
    );

    // Stage 1: word travels alongside the table read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_valid <= 1'b0;
            s1_hdr   <= 1'b0;
            s1_data  <= '0;
            s1_port  <= PORT_LINE;
        end else begin
            s1_valid <= accept;
            s1_hdr   <= header;
            s1_data  <= in_data;
            s1_port  <= in_port;
        end
    end

    // Stage 2: route latched on the header, held for the cell.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_soc   <= 1'b0;
            out_data  <= '0;
            out_dest  <= '0;
        end else begin
            out_valid <= s1_valid;
            out_soc   <= s1_valid && s1_hdr;
            out_data  <= s1_data;
            if (s1_valid && s1_hdr) begin
                out_dest <= route;
            end
        end
    end

endmodule

// File: rtl/flow_route_lookup_chk.sv
module flow_route_lookup_chk #(
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic              in_soc,
    input logic [DATA_W-1:0] in_data,
    input logic              out_valid,
    input logic              out_soc,
    input logic [DATA_W-1:0] out_data,
    input logic [1:0]        out_dest
);
    // R3: a header on the output was a flagged valid word two cycles earlier
    a_r3_soc_latency: assert property (@(posedge clk) disable iff (!rst_n)
        out_soc |-> ($past(in_valid, 2) && $past(in_soc, 2)));

    // R3: forwarded data is the input word delayed by two cycles
    a_r3_data_delay: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_data == $past(in_data, 2)));

    // R2: nothing is emitted without a valid input word two cycles earlier
    a_r2_no_phantom: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(in_valid, 2));

    // R4: the tag does not move on body words
    a_r4_dest_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_soc) |-> $stable(out_dest));

    // R12: output is quiet straight after a reset cycle
    a_r12_reset_quiet: assert property (@(posedge clk)
        !rst_n |=> (!out_valid && out_dest == 2'd0));

endmodule

bind flow_route_lookup flow_route_lookup_chk #(.DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_soc    (in_soc),
    .in_data   (in_data),
    .out_valid (out_valid),
    .out_soc   (out_soc),
    .out_data  (out_data),
    .out_dest  (out_dest)
);

// File: tb/flow_route_lookup_tb.sv
module flow_route_lookup_tb;

    localparam int CELLW = 13;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_soc = 1'b0;
    logic [1:0]  in_port = 2'd0;
    logic [31:0] in_data = '0;
    logic        wr_en = 1'b0;
    logic        wr_tbl = 1'b0;
    logic [1:0]  wr_port = 2'd0;
    logic [9:0]  wr_idx = '0;
    logic        wr_valid = 1'b0;
    logic [1:0]  wr_dest = 2'd0;
    logic        out_valid;
    logic        out_soc;
    logic [31:0] out_data;
    logic [1:0]  out_dest;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    flow_route_lookup u_dut (
        .clk(clk), .rst_n(rst_n),
        .in_valid(in_valid), .in_soc(in_soc), .in_port(in_port), .in_data(in_data),
        .wr_en(wr_en), .wr_tbl(wr_tbl), .wr_port(wr_port), .wr_idx(wr_idx),
        .wr_valid(wr_valid), .wr_dest(wr_dest),
        .out_valid(out_valid), .out_soc(out_soc), .out_data(out_data), .out_dest(out_dest)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] mk_hdr(input logic [11:0] vpi, input logic [15:0] vci);
        return {vpi, vci, 4'h0};
    endfunction

    function automatic logic [31:0] payload(input int i);
        return 32'h5A00_0000 | 32'(i);
    endfunction

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        in_valid = 1'b0;
        wr_en = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic tbl_wr(input logic t, input logic [9:0] idx, input logic [1:0] p,
                          input logic v, input logic [1:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_tbl = t; wr_idx = idx; wr_port = p; wr_valid = v; wr_dest = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // Sends one cell; optionally raises in_soc on word 5 and/or writes a table slot
    // in the same cycle as the header.
    task automatic send_cell(input string req, input logic [1:0] p, input logic [11:0] vpi,
                             input logic [15:0] vci, input logic [1:0] exp_dest,
                             input bit mid_soc, input bit col, input logic ct,
                             input logic [9:0] cidx, input logic [1:0] cp,
                             input logic cv, input logic [1:0] cd);
        logic [31:0] h;
        h = mk_hdr(vpi, vci);
        for (int i = 0; i < CELLW; i++) begin
            @(negedge clk);
            if (i == 2) begin
                chk(out_valid && out_soc && out_data == h, "R3 header framing", out_data, h);
                chk(out_dest == exp_dest, req, 32'(out_dest), 32'(exp_dest));
            end
            if (i == 7) begin
                chk(out_valid && !out_soc && out_data == payload(5) && out_dest == exp_dest,
                    "R4/R1 body word held route, mid flag ignored",
                    {out_soc, 27'd0, out_dest, 2'd0}, {1'b0, 27'd0, exp_dest, 2'd0});
            end
            in_valid = 1'b1;
            in_soc   = (i == 0) || (mid_soc && i == 5);
            in_port  = p;
            in_data  = (i == 0) ? h : payload(i);
            wr_en    = col && (i == 0);
            if (col && i == 0) begin
                wr_tbl = ct; wr_idx = cidx; wr_port = cp; wr_valid = cv; wr_dest = cd;
            end
        end
        @(negedge clk);
        in_valid = 1'b0; in_soc = 1'b0; wr_en = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    task automatic test_defaults();
        send_cell("R8 default line->switch", 2'd0, 12'h011, 16'h0022, 2'd1, 0, 0, 0, '0, 2'd0, 0, 2'd0);
        send_cell("R8 default switch->line", 2'd1, 12'h011, 16'h0022, 2'd0, 0, 0, 0, '0, 2'd0, 0, 2'd0);
        send_cell("R8 default modA->switch", 2'd2, 12'h011, 16'h0022, 2'd1, 0, 0, 0, '0, 2'd0, 0, 2'd0);
        send_cell("R8 default modB->line",   2'd3, 12'h011, 16'h0022, 2'd0, 0, 0, 0, '0, 2'd0, 0, 2'd0);
    endtask

    task automatic test_path_and_circuit();
        tbl_wr(1'b1, 10'd5, 2'd0, 1'b1, 2'd2);   // path 5, line card slot -> module A
        send_cell("R7/R10 path entry ingress to module", 2'd0, 12'h005, 16'h004D, 2'd2, 0, 0, 0, '0, 2'd0, 0, 2'd0);
        send_cell("R9 other port slot untouched", 2'd1, 12'h005, 16'h004D, 2'd0, 0, 0, 0, '0, 2'd0, 0, 2'd0);
        tbl_wr(1'b0, 10'd77, 2'd0, 1'b1, 2'd0);  // circuit 77, line card slot -> loopback
        send_cell("R6/R10 circuit overrides path, loopback", 2'd0, 12'h005, 16'h004D, 2'd0, 0, 0, 0, '0, 2'd0, 0, 2'd0);
        send_cell("R5 circuit index uses low 10 bits", 2'd0, 12'h005, 16'h044D, 2'd0, 0, 0, 0, '0, 2'd0, 0, 2'd0);
        send_cell("R5 path index uses low 10 bits", 2'd0, 12'h405, 16'h0003, 2'd2, 0, 0, 0, '0, 2'd0, 0, 2'd0);
        tbl_wr(1'b0, 10'd9, 2'd1, 1'b1, 2'd3);   // circuit 9, switch slot -> module B
        send_cell("R10 egress to module B", 2'd1, 12'h000, 16'h0009, 2'd3, 0, 0, 0, '0, 2'd0, 0, 2'd0);
    endtask

    task automatic test_collision();
        send_cell("R11 colliding write returns old route", 2'd0, 12'h005, 16'h004D, 2'd0,
                  0, 1, 1'b0, 10'd77, 2'd0, 1'b0, 2'd0);
        send_cell("R11/R7 new contents after write, path fallback", 2'd0, 12'h005, 16'h004D, 2'd2,
                  0, 0, 0, '0, 2'd0, 0, 2'd0);
    endtask

    task automatic test_framing();
        send_cell("R1 cell with inner start flag", 2'd1, 12'h000, 16'h0009, 2'd3, 1, 0, 0, '0, 2'd0, 0, 2'd0);
        @(negedge clk);
        in_valid = 1'b1; in_soc = 1'b0; in_data = 32'hDEAD_BEEF;
        @(negedge clk);
        in_valid = 1'b0;
        @(negedge clk);
        chk(!out_valid, "R2 stray word dropped", 32'(out_valid), 32'd0);
        @(negedge clk);
        chk(!out_valid, "R2 stray word dropped (late)", 32'(out_valid), 32'd0);
    endtask

    task automatic test_reset_clears();
        do_reset();
        chk(!out_valid && out_dest == 2'd0, "R12 outputs after reset", {out_valid, 29'd0, out_dest}, 32'd0);
        send_cell("R12 tables invalid after reset", 2'd0, 12'h005, 16'h004D, 2'd1, 0, 0, 0, '0, 2'd0, 0, 2'd0);
    endtask

    initial begin
        do_reset();
        chk(!out_valid, "R12 out_valid after reset", 32'(out_valid), 32'd0);
        chk(out_dest == 2'd0, "R12 out_dest after reset", 32'(out_dest), 32'd0);
        test_defaults();
        test_path_and_circuit();
        test_collision();
        test_framing();
        test_reset_clears();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule